// File: doc/BRIEF.md
# Ordered store buffer with two fence strengths

This block sits between instruction retirement and the data cache. Every retired store is written into a small in-order queue, and the queue hands its oldest entry to memory over a valid/ready write port. An entry leaves the queue only on a completed handshake. Loads are not held back by the stores waiting in the queue. A load looks up its word address in the queue. When one or more buffered stores match that address, the load takes the data of the most recently accepted matching store. When none match, the load goes to memory as usual.

Two fence strengths are provided. A store fence holds later stores at the input until every earlier store has drained, and loads keep flowing past it. A full fence holds both later stores and later loads until the queue is empty. Only one fence is outstanding at a time. A fence finishes one cycle after the queue is first seen empty with that fence pending.

Top module: `sbf_top`

## Requirements
- R1: After reset the queue is empty: `mem_valid` is 0, and `st_ready`, `ld_ready` and `fn_ready` are all 1.
- R2: `mem_addr`/`mem_data` always present the oldest buffered store, so stores reach memory in the order they were accepted. While `mem_valid` is 1 and `mem_ready` is 0, both values hold steady.
- R3: `mem_valid` is 1 exactly when the queue holds at least one store. An entry is removed only in a cycle where `mem_valid` and `mem_ready` are both 1.
- R4: When the queue holds DEPTH stores, `st_ready` is 0 and a presented store is not taken. A store is taken when `st_valid` and `st_ready` are both 1.
- R5: With no full fence pending, `ld_ready` is 1 whatever the queue holds, so loads bypass buffered stores.
- R6: `ld_hit` is 1 when `ld_valid` and `ld_ready` are 1 and some buffered store has address `ld_addr`. `ld_data` then carries the data of the youngest such store, and is 0 when `ld_hit` is 0. A store accepted in the same cycle as the lookup is not visible to that lookup. An entry draining in that cycle is still visible.
- R7: A fence accepted with `fn_full` = 1 (full fence) drives both `st_ready` and `ld_ready` to 0 from the next cycle until it completes.
- R8: A fence accepted with `fn_full` = 0 (store fence) drives `st_ready` to 0 until it completes and leaves `ld_ready` at 1.
- R9: A fence is accepted when `fn_valid` and `fn_ready` are 1. `fn_ready` is then 0 until the fence completes. Completion takes effect on the edge that follows the first cycle in which the fence is pending and the queue is empty. A store taken in the acceptance cycle counts as older than the fence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Retired store presented |
| st_ready | output | 1 | Store can be taken this cycle |
| st_addr | input | AW | Store word address |
| st_data | input | DW | Store data |
| ld_valid | input | 1 | Load lookup presented |
| ld_ready | output | 1 | Load may be performed this cycle |
| ld_addr | input | AW | Load word address |
| ld_hit | output | 1 | Load is served from the queue |
| ld_data | output | DW | Forwarded data, 0 without a hit |
| fn_valid | input | 1 | Fence request |
| fn_full | input | 1 | 1 = full fence, 0 = store fence |
| fn_ready | output | 1 | No fence pending; a request is taken |
| mem_valid | output | 1 | Oldest store offered to memory |
| mem_ready | input | 1 | Memory takes the offered store |
| mem_addr | output | AW | Address of the oldest store |
| mem_data | output | DW | Data of the oldest store |

## Verification
Two functions can fall in the same cycle. A load may look up an address whose only copy is the head entry, in the same cycle that entry completes its memory handshake. A store may also be offered in the cycle a fence is taken. The sweep sets up the first case by filling the queue and then draining it with `mem_ready` high while it loads the first address. It sets up the second case by raising `st_valid` together with `fn_valid` on an empty queue. A bench model holds the queue contents and fence state and computes the expected outcome: the draining entry must still be forwarded, and the store must enter the queue and delay fence completion until it has drained.

// File: rtl/sbf_pkg.sv
package sbf_pkg;

    // Strength of a fence request; the encoding matches the fn_full pin.
    typedef enum logic {
        FENCE_STORE = 1'b0,
        FENCE_FULL  = 1'b1
    } fence_e;

endpackage

// File: rtl/sbf_queue.sv
// Circular in-order storage for buffered stores.
module sbf_queue #(
    parameter int DEPTH = 8,
    parameter int AW    = 16,
    parameter int DW    = 32,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH) + 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     push,
    input  logic [AW-1:0]            push_addr,
    input  logic [DW-1:0]            push_data,
    input  logic                     pop,
    output logic [PW-1:0]            head_ptr,
    output logic [CW-1:0]            count,
    output logic [AW-1:0]            head_addr,
    output logic [DW-1:0]            head_data,
    output logic [DEPTH-1:0][AW-1:0] slot_addr,
    output logic [DEPTH-1:0][DW-1:0] slot_data
);

    typedef struct packed {
        logic [DEPTH-1:0][AW-1:0] addr;
        logic [DEPTH-1:0][DW-1:0] data;
        logic [PW-1:0]            head;
        logic [PW-1:0]            tail;
        logic [CW-1:0]            count;
    } q_state_t;

    q_state_t q_q, q_d;

    always_comb begin
        q_d = q_q;
        if (push) begin
            q_d.addr[q_q.tail] = push_addr;
            q_d.data[q_q.tail] = push_data;
            q_d.tail           = q_q.tail + PW'(1);
        end
        if (pop) begin
            q_d.head = q_q.head + PW'(1);
        end
        q_d.count = q_q.count + CW'(push) - CW'(pop);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_q <= '0;
        end else begin
            q_q <= q_d;
        end
    end

    assign head_ptr  = q_q.head;
    assign count     = q_q.count;
    assign head_addr = q_q.addr[q_q.head];
    assign head_data = q_q.data[q_q.head];
    assign slot_addr = q_q.addr;
    assign slot_data = q_q.data;

endmodule

// File: rtl/sbf_fwd.sv
// Age-ordered search: returns the youngest buffered store matching an address.
module sbf_fwd #(
    parameter int DEPTH = 8,
    parameter int AW    = 16,
    parameter int DW    = 32,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH) + 1
) (
    input  logic [PW-1:0]            head_ptr,
    input  logic [CW-1:0]            count,
    input  logic [DEPTH-1:0][AW-1:0] slot_addr,
    input  logic [DEPTH-1:0][DW-1:0] slot_data,
    input  logic [AW-1:0]            look_addr,
    output logic                     hit,
    output logic [DW-1:0]            hit_data
);

    logic [DEPTH-1:0]         age_match;
    logic [DEPTH-1:0][DW-1:0] age_data;

    // Age k = k-th oldest live entry, counted from the head.
    for (genvar k = 0; k < DEPTH; k++) begin : g_age
        logic [PW-1:0] idx;
        assign idx          = head_ptr + PW'(k);
        assign age_match[k] = (CW'(k) < count) && (slot_addr[idx] == look_addr);
        assign age_data[k]  = slot_data[idx];
    end

    // Later (younger) matches override earlier ones.
    always_comb begin
        hit      = 1'b0;
        hit_data = '0;
        for (int k = 0; k < DEPTH; k++) begin
            if (age_match[k]) begin
                hit      = 1'b1;
                hit_data = age_data[k];
            end
        end
    end

endmodule

// File: rtl/sbf_fence.sv
// Holds at most one outstanding fence and derives the stall terms.
module sbf_fence
    import sbf_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   fn_valid,
    input  fence_e fn_kind,
    input  logic   buf_empty,
    output logic   fn_ready,
    output logic   hold_st,
    output logic   hold_ld
);

    typedef struct packed {
        logic   pend;
        fence_e kind;
    } f_state_t;

    f_state_t f_q, f_d;

    always_comb begin
        f_d = f_q;
        if (f_q.pend) begin
            if (buf_empty) begin
                f_d.pend = 1'b0;
            end
        end else if (fn_valid) begin
            f_d.pend = 1'b1;
            f_d.kind = fn_kind;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            f_q <= '{pend: 1'b0, kind: FENCE_STORE};
        end else begin
            f_q <= f_d;
        end
    end

    assign fn_ready = !f_q.pend;
    assign hold_st  = f_q.pend;
    assign hold_ld  = f_q.pend && (f_q.kind == FENCE_FULL);

endmodule

// File: rtl/sbf_top.sv
module sbf_top
    import sbf_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int AW    = 16,
    parameter int DW    = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          st_valid,
    output logic          st_ready,
    input  logic [AW-1:0] st_addr,
    input  logic [DW-1:0] st_data,
    input  logic          ld_valid,
    output logic          ld_ready,
    input  logic [AW-1:0] ld_addr,
    output logic          ld_hit,
    output logic [DW-1:0] ld_data,
    input  logic          fn_valid,
    input  logic          fn_full,
    output logic          fn_ready,
    output logic          mem_valid,
    input  logic          mem_ready,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_data
);

    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH) + 1;

    logic [PW-1:0]            head_ptr;
    logic [CW-1:0]            count;
    logic [DEPTH-1:0][AW-1:0] slot_addr;
    logic [DEPTH-1:0][DW-1:0] slot_data;
    logic                     push, pop, buf_full, buf_empty;
    logic                     hold_st, hold_ld;
    logic                     fwd_hit;
    logic [DW-1:0]            fwd_data;
    fence_e                   fn_kind;

    assign buf_full  = (count == CW'(DEPTH));
    assign buf_empty = (count == '0);
    assign st_ready  = !buf_full && !hold_st;
    assign push      = st_valid && st_ready;
    assign mem_valid = !buf_empty;
    assign pop       = mem_valid && mem_ready;
    assign ld_ready  = !hold_ld;
    assign ld_hit    = ld_valid && ld_ready && fwd_hit;
    assign ld_data   = ld_hit ? fwd_data : '0;
    assign fn_kind   = fn_full ? FENCE_FULL : FENCE_STORE;

    sbf_queue #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) queue_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_addr (st_addr),
        .push_data (st_data),
        .pop       (pop),
        .head_ptr  (head_ptr),
        .count     (count),
        .head_addr (mem_addr),
        .head_data (mem_data),
        .slot_addr (slot_addr),
        .slot_data (slot_data)
    );

    sbf_fwd #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) fwd_i (
        .head_ptr  (head_ptr),
        .count     (count),
        .slot_addr (slot_addr),
        .slot_data (slot_data),
        .look_addr (ld_addr),
        .hit       (fwd_hit),
        .hit_data  (fwd_data)
    );

    sbf_fence fence_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .fn_valid  (fn_valid),
        .fn_kind   (fn_kind),
        .buf_empty (buf_empty),
        .fn_ready  (fn_ready),
        .hold_st   (hold_st),
        .hold_ld   (hold_ld)
    );

endmodule

// File: rtl/sbf_chk.sv
module sbf_chk #(
    parameter int DEPTH = 8,
    parameter int AW    = 16,
    parameter int DW    = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          st_valid,
    input logic          st_ready,
    input logic          ld_valid,
    input logic          ld_ready,
    input logic          ld_hit,
    input logic          fn_valid,
    input logic          fn_ready,
    input logic          mem_valid,
    input logic          mem_ready,
    input logic [AW-1:0] mem_addr,
    input logic [DW-1:0] mem_data
);

    localparam int CW = $clog2(DEPTH) + 1;

    // Occupancy rebuilt from the port handshakes only.
    logic [CW-1:0] occ;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            occ <= '0;
        end else begin
            occ <= occ + CW'(st_valid && st_ready) - CW'(mem_valid && mem_ready);
        end
    end

    // R4
    occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= CW'(DEPTH));

    // R4
    full_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == CW'(DEPTH)) |-> !st_ready);

    // R3
    drain_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid == (occ != '0));

    // R2
    head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_data)));

    // R9
    fence_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fn_valid && fn_ready) |=> !fn_ready);

    // R7
    fence_st_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fn_ready |-> !st_ready);

    // R5
    ld_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_ready |-> !fn_ready);

    // R6
    fwd_needs_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_hit |-> (ld_valid && ld_ready && mem_valid));

endmodule

bind sbf_top sbf_chk #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .st_valid  (st_valid),
    .st_ready  (st_ready),
    .ld_valid  (ld_valid),
    .ld_ready  (ld_ready),
    .ld_hit    (ld_hit),
    .fn_valid  (fn_valid),
    .fn_ready  (fn_ready),
    .mem_valid (mem_valid),
    .mem_ready (mem_ready),
    .mem_addr  (mem_addr),
    .mem_data  (mem_data)
);

// File: tb/sbf_top_tb_top.sv
module sbf_top_tb_top;

    localparam int DEPTH = 4;
    localparam int AW    = 3;
    localparam int DW    = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          st_valid = 1'b0, ld_valid = 1'b0, fn_valid = 1'b0, fn_full = 1'b0, mem_ready = 1'b0;
    logic [AW-1:0] st_addr = '0, ld_addr = '0;
    logic [DW-1:0] st_data = '0;
    logic          st_ready, ld_ready, ld_hit, fn_ready, mem_valid;
    logic [DW-1:0] ld_data, mem_data;
    logic [AW-1:0] mem_addr;

    always #10 clk = ~clk;   // 50 MHz

    sbf_top #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr), .st_data(st_data),
        .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_addr(ld_addr), .ld_hit(ld_hit), .ld_data(ld_data),
        .fn_valid(fn_valid), .fn_full(fn_full), .fn_ready(fn_ready),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_data(mem_data)
    );

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    // Reference model of queue contents and fence state.
    logic [AW-1:0] mq_a[$];
    logic [DW-1:0] mq_d[$];
    bit            m_pend = 1'b0;
    bit            m_full = 1'b0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // One clock: drive after the falling edge, check, then advance the model.
    task automatic cyc(input bit sv, input int sa, input int sd, input bit lv, input int la,
                       input bit fv, input bit fk, input bit mr);
        int            cnt;
        bit            e_st, e_ld, e_fn, e_hit;
        logic [DW-1:0] e_ld_d;
        @(negedge clk);
        st_valid = sv; st_addr = AW'(sa); st_data = DW'(sd);
        ld_valid = lv; ld_addr = AW'(la);
        fn_valid = fv; fn_full = fk; mem_ready = mr;
        #1;
        cnt    = mq_a.size();
        e_st   = (cnt < DEPTH) && !m_pend;
        e_ld   = !(m_pend && m_full);
        e_fn   = !m_pend;
        e_hit  = 1'b0;
        e_ld_d = '0;
        for (int i = 0; i < cnt; i++) begin
            if (mq_a[i] == AW'(la)) begin
                e_hit  = 1'b1;
                e_ld_d = mq_d[i];
            end
        end
        if (!(lv && e_ld)) begin
            e_hit  = 1'b0;
            e_ld_d = '0;
        end
        chk("R4/R7/R8 st_ready", 32'(st_ready), 32'(e_st));
        chk("R5/R7/R8 ld_ready", 32'(ld_ready), 32'(e_ld));
        chk("R9 fn_ready", 32'(fn_ready), 32'(e_fn));
        chk("R3 mem_valid", 32'(mem_valid), 32'(cnt != 0));
        if (cnt != 0) begin
            chk("R2 mem_addr", 32'(mem_addr), 32'(mq_a[0]));
            chk("R2 mem_data", 32'(mem_data), 32'(mq_d[0]));
        end
        chk("R6 ld_hit", 32'(ld_hit), 32'(e_hit));
        chk("R6 ld_data", 32'(ld_data), 32'(e_ld_d));
        if (m_pend && cnt == 0) begin
            m_pend = 1'b0;
        end else if (!m_pend && fv) begin
            m_pend = 1'b1;
            m_full = fk;
        end
        if (cnt != 0 && mr) begin
            void'(mq_a.pop_front());
            void'(mq_d.pop_front());
        end
        if (sv && e_st) begin
            mq_a.push_back(AW'(sa));
            mq_d.push_back(DW'(sd));
        end
    endtask

    task automatic idle(input int n, input bit mr);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0, 0, mr);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1 mem_valid", 32'(mem_valid), 0);
        chk("R1 st_ready", 32'(st_ready), 1);
        chk("R1 ld_ready", 32'(ld_ready), 1);
        chk("R1 fn_ready", 32'(fn_ready), 1);

        // Sweep every 4-entry address pattern over 4 addresses (R2 R3 R4 R6).
        for (int p = 0; p < 256; p++) begin
            for (int k = 0; k < 4; k++) cyc(1, (p >> (2 * k)) & 3, (p * 4 + k) & 255, 0, 0, 0, 0, 0);
            cyc(1, 7, 99, 0, 0, 0, 0, 0);                  // R4: full, refused
            for (int a = 0; a < 8; a++) cyc(0, 0, 0, 1, a, 0, 0, 0);
            // Drain while loading the first address: head still forwards (R6).
            for (int k = 0; k < 4; k++) cyc(0, 0, 0, 1, p & 3, 0, 0, 1);
        end

        // Store and load of one address in one cycle: store not visible yet (R6).
        cyc(1, 6, 8'h66, 1, 6, 0, 0, 0);
        cyc(0, 0, 0, 1, 6, 0, 0, 0);
        idle(2, 1);

        // Store fence with entries queued (R8), then full fence (R7), each with traffic.
        for (int f = 0; f < 2; f++) begin
            for (int k = 0; k < 3; k++) cyc(1, k, 8'h40 + k, 0, 0, 0, 0, 0);
            cyc(0, 0, 0, 1, 1, 1, f[0], 0);
            for (int k = 0; k < 3; k++) cyc(1, 5, 8'h55, 1, k, 1, 1, 0);
            for (int k = 0; k < 6; k++) cyc(1, 4, 8'h77 + k, 1, 4, 0, 0, 1);
            idle(5, 1);
        end

        // Fence on empty queue with a store in the same cycle (R9).
        for (int f = 0; f < 2; f++) begin
            cyc(1, 3, 8'h33, 1, 3, 1, f[0], 0);
            cyc(1, 2, 8'h22, 1, 3, 0, 0, 0);
            cyc(1, 2, 8'h22, 1, 3, 0, 0, 1);
            for (int k = 0; k < 4; k++) cyc(1, 2, 8'h23 + k, 1, 2, 0, 0, 1);
            idle(5, 1);
        end

        // Mixed traffic from a pseudo-random stream.
        for (int i = 0; i < 6000; i++) begin
            cyc(($urandom % 10) < 6, $urandom % 8, $urandom % 256,
                ($urandom % 10) < 7, $urandom % 8,
                ($urandom % 16) == 0, $urandom % 2, ($urandom % 2) == 1);
        end

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule